// File: doc/BRIEF.md
# Side-Channel Byte Buffer

This block sits behind a digital-audio frame decoder. It gathers the per-subframe side-channel bits into bytes: one channel-status bit, one user bit and four auxiliary bits per subframe. Each finished byte goes into a 32-byte RAM. The two-bit buffer mode decides which streams are kept and where they land. A host reads any byte through a combinational read port while the RAM keeps filling.

Bits are packed least-significant first. Each stream has its own write pointer, which wraps inside the stream's region. All pointers start again at the start of every block, and any partly built byte is dropped at that point. Three level flags tell the host which half of a region is being filled, so it can read the other half safely. A one-cycle interrupt pulse marks the start of a new block pass.

Top module: `sc_side_buffer`

## Requirements
- R1: After reset every RAM byte reads 0, `flag_o` is 3'b100 and `irq_o` is 0.
- R2: With `rd_en_i` high, `rd_data_o` returns the RAM byte at `rd_addr_i` in the same cycle, showing its contents from before that clock edge. With `rd_en_i` low, `rd_data_o` is 0. Reads never change RAM contents, pointers or flags, and bytes 04h-07h are never written.
- R3: User bits from both subframes fill bytes 00h-03h. Bit k of a byte is the k-th user bit received for that byte. Each byte is committed on its eighth bit, and the pointer wraps from 03h to 00h.
- R4: In every mode, channel-status bits from the first subframe of each frame (`sf_second_i`=0) fill bytes 08h-0Fh, least-significant bit first. So the byte at 08h after a block start holds frames 0-7 of that block, and the pointer wraps from 0Fh to 08h.
- R5: In mode 1, `aux_i` fills bytes 10h-1Fh on every subframe. The nibble of an even-numbered subframe goes into bits 3:0 and the nibble of the next subframe goes into bits 7:4, with `aux_i[0]` lowest. The pointer wraps from 1Fh to 10h.
- R6: In mode 2, channel-status bits from the second subframe fill bytes 10h-17h, least-significant bit first, and the pointer wraps within that range. In modes 0 and 3, nothing is written at 10h-1Fh, and the auxiliary and second-subframe pointers hold.
- R7: `flag_o[0]` is 1 exactly when the next user byte goes to 02h or 03h. Because the auxiliary stream fills at four times the rate into a region four times the size, this is also the upper half 18h-1Fh of the auxiliary region.
- R8: `flag_o[1]` is 1 exactly when the channel-status byte being filled is at 0Ch-0Fh.
- R9: `flag_o[2]` is 1 from a block start until the eighth channel-status byte of that block has been committed. `irq_o` is high for exactly the one cycle after each rising edge of `flag_o[2]`.
- R10: A block start is a subframe strobe with `sf_second_i`=0 and `blk_start_i`=1. It drops any partly built byte in every stream and restarts all pointers at their region base. The second-subframe stream restarts on the second subframe of that same frame. `blk_start_i` has no effect on a second subframe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Buffer mode: 0 status only, 1 status plus aux, 2 status of both subframes, 3 as 0 |
| sf_valid_i | input | 1 | One-cycle strobe per decoded subframe |
| sf_second_i | input | 1 | The strobed subframe is the second of its frame |
| blk_start_i | input | 1 | The strobed subframe begins a block |
| c_bit_i | input | 1 | Channel-status bit of the subframe |
| u_bit_i | input | 1 | User bit of the subframe |
| aux_i | input | 4 | Auxiliary nibble of the subframe |
| rd_en_i | input | 1 | Host read enable |
| rd_addr_i | input | 5 | Host read byte address |
| rd_data_o | output | 8 | Host read data |
| flag_o | output | 3 | [0] user/aux half, [1] status half, [2] first block pass |
| irq_o | output | 1 | One-cycle pulse on rising edge of flag_o[2] |

## Verification
The assertions check several rules on every cycle. Commit addresses stay inside their own region, and two write ports never hit the same byte. Nothing is written and no flag moves in a cycle without a subframe strobe. The auxiliary and second-subframe streams never write together. The interrupt is always a single-cycle pulse, and a disabled read returns zero. Only the bench's scenarios can show the rest: the actual byte values and bit order of each stream, pointer wrapping, the dropped partial byte at a mid-byte block start, and the flag-2 timing across block passes. These are compared every cycle against a reference model, while random host reads sample the whole address space.

// File: rtl/sc_buf_pkg.sv
`timescale 1ns/1ps
package sc_buf_pkg;
  localparam int AW        = 5;
  localparam int DW        = 8;
  localparam int DEPTH     = 1 << AW;
  localparam int USR_BASE  = 0;
  localparam int USR_PW    = 2;
  localparam int CSA_BASE  = 8;
  localparam int CSA_PW    = 3;
  localparam int SIDE_BASE = 16;
  localparam int AUX_PW    = 4;
  localparam int CSB_PW    = 3;
  localparam int AUX_BITS  = 4;
  localparam int N_WPORT   = 3;

  typedef enum logic [1:0] {
    MODE_CS_ONLY = 2'd0,
    MODE_CS_AUX  = 2'd1,
    MODE_CS_PAIR = 2'd2,
    MODE_ALT     = 2'd3
  } buf_mode_e;
endpackage

// File: rtl/sc_collector.sv
`timescale 1ns/1ps
module sc_collector #(
  parameter int BITS  = 1,
  parameter int PTR_W = 2,
  parameter int AW    = 5,
  parameter int BASE  = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             restart_i,
  input  logic [BITS-1:0]  bits_i,
  output logic             we_o,
  output logic [AW-1:0]    waddr_o,
  output logic [7:0]       wdata_o,
  output logic [PTR_W-1:0] ptr_o
);
  localparam logic [3:0]    STEP   = 4'(BITS);
  localparam logic [AW-1:0] BASE_A = AW'(BASE);
  localparam logic [AW:0]   SPAN   = (AW+1)'(1 << PTR_W);

  logic [7:0]       acc_q, acc_eff, byte_c;
  logic [2:0]       cnt_q, cnt_eff;
  logic [PTR_W-1:0] ptr_q, ptr_eff;
  logic [3:0]       cnt_sum;
  logic             done;

  // a block restart drops the partial byte and rewinds the pointer
  always_comb begin
    cnt_eff = restart_i ? '0 : cnt_q;
    ptr_eff = restart_i ? '0 : ptr_q;
    acc_eff = restart_i ? '0 : acc_q;
    byte_c  = acc_eff | (8'(bits_i) << cnt_eff);
    cnt_sum = {1'b0, cnt_eff} + STEP;
    done    = (cnt_sum == 4'd8);
  end

  assign we_o    = en_i & done;
  assign waddr_o = BASE_A + AW'(ptr_eff);
  assign wdata_o = byte_c;
  assign ptr_o   = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      cnt_q <= '0;
      ptr_q <= '0;
    end else if (en_i) begin
      if (done) begin
        acc_q <= '0;
        cnt_q <= '0;
        ptr_q <= ptr_eff + 1'b1;
      end else begin
        acc_q <= byte_c;
        cnt_q <= cnt_sum[2:0];
        ptr_q <= ptr_eff;
      end
    end
  end

  // R3 R4 R5 R6: commits stay inside the stream's region
  a_r3_commit_in_region: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> (({1'b0, waddr_o} - {1'b0, BASE_A}) < SPAN));

  // R10: after a restart the byte restarts from its first slot
  a_r10_restart_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && restart_i && !we_o) |=> (cnt_q == STEP[2:0] && ptr_q == '0));
endmodule

// File: rtl/sc_buf_ram.sv
`timescale 1ns/1ps
module sc_buf_ram #(
  parameter int AW = 5,
  parameter int NW = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NW-1:0]         we_i,
  input  logic [NW-1:0][AW-1:0] waddr_i,
  input  logic [NW-1:0][7:0]    wdata_i,
  input  logic [AW-1:0]         rd_addr_i,
  output logic [7:0]            rd_data_o
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < DEPTH; e++) mem_q[e] <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++)
        for (int p = 0; p < NW; p++)
          if (we_i[p] && waddr_i[p] == AW'(e)) mem_q[e] <= wdata_i[p];
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];

  for (genvar a = 0; a < NW; a++) begin : g_pa
    for (genvar b = a + 1; b < NW; b++) begin : g_pb
      // R6: regions are disjoint, so ports never collide
      a_r6_port_addr_distinct: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i[a] && we_i[b]) |-> (waddr_i[a] != waddr_i[b]));
    end
  end
endmodule

// File: rtl/sc_side_buffer.sv
`timescale 1ns/1ps
module sc_side_buffer
  import sc_buf_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic          sf_valid_i,
  input  logic          sf_second_i,
  input  logic          blk_start_i,
  input  logic          c_bit_i,
  input  logic          u_bit_i,
  input  logic [3:0]    aux_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic [2:0]    flag_o,
  output logic          irq_o
);
  buf_mode_e mode;
  logic first_stb, second_stb, blk_rst;
  logic pend_q, done_q, prev_q, flag2;

  logic          usr_we, csa_we, aux_we, csb_we;
  logic [AW-1:0] usr_addr, csa_addr, aux_addr, csb_addr;
  logic [7:0]    usr_data, csa_data, aux_data, csb_data;
  logic [USR_PW-1:0] usr_ptr;
  logic [CSA_PW-1:0] csa_ptr;
  logic [AUX_PW-1:0] aux_ptr;
  logic [CSB_PW-1:0] csb_ptr;

  logic [N_WPORT-1:0]         ram_we;
  logic [N_WPORT-1:0][AW-1:0] ram_addr;
  logic [N_WPORT-1:0][7:0]    ram_data;
  logic [7:0]                 ram_rd;

  assign mode       = buf_mode_e'(mode_i);
  assign first_stb  = sf_valid_i & ~sf_second_i;
  assign second_stb = sf_valid_i & sf_second_i;
  assign blk_rst    = first_stb & blk_start_i;

  sc_collector #(.BITS(1), .PTR_W(USR_PW), .AW(AW), .BASE(USR_BASE)) u_usr (
    .clk_i, .rst_ni, .en_i(sf_valid_i), .restart_i(blk_rst), .bits_i(u_bit_i),
    .we_o(usr_we), .waddr_o(usr_addr), .wdata_o(usr_data), .ptr_o(usr_ptr));

  sc_collector #(.BITS(1), .PTR_W(CSA_PW), .AW(AW), .BASE(CSA_BASE)) u_csa (
    .clk_i, .rst_ni, .en_i(first_stb), .restart_i(blk_rst), .bits_i(c_bit_i),
    .we_o(csa_we), .waddr_o(csa_addr), .wdata_o(csa_data), .ptr_o(csa_ptr));

  sc_collector #(.BITS(AUX_BITS), .PTR_W(AUX_PW), .AW(AW), .BASE(SIDE_BASE)) u_aux (
    .clk_i, .rst_ni, .en_i(sf_valid_i && mode == MODE_CS_AUX), .restart_i(blk_rst),
    .bits_i(aux_i), .we_o(aux_we), .waddr_o(aux_addr), .wdata_o(aux_data), .ptr_o(aux_ptr));

  sc_collector #(.BITS(1), .PTR_W(CSB_PW), .AW(AW), .BASE(SIDE_BASE)) u_csb (
    .clk_i, .rst_ni, .en_i(second_stb && mode == MODE_CS_PAIR), .restart_i(pend_q),
    .bits_i(c_bit_i), .we_o(csb_we), .waddr_o(csb_addr), .wdata_o(csb_data), .ptr_o(csb_ptr));

  // port 2 is shared by the two mode-exclusive side streams
  always_comb begin
    ram_we   = {aux_we | csb_we, csa_we, usr_we};
    ram_addr = {aux_we ? aux_addr : csb_addr, csa_addr, usr_addr};
    ram_data = {aux_we ? aux_data : csb_data, csa_data, usr_data};
  end

  sc_buf_ram #(.AW(AW), .NW(N_WPORT)) u_ram (
    .clk_i, .rst_ni, .we_i(ram_we), .waddr_i(ram_addr), .wdata_i(ram_data),
    .rd_addr_i, .rd_data_o(ram_rd));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      done_q <= 1'b0;
      prev_q <= 1'b1;
    end else begin
      if (second_stb)   pend_q <= 1'b0;
      else if (blk_rst) pend_q <= 1'b1;
      if (blk_rst)                     done_q <= 1'b0;
      else if (csa_we && csa_ptr == '1) done_q <= 1'b1;
      prev_q <= flag2;
    end
  end

  assign flag2     = ~done_q;
  assign flag_o    = {flag2, csa_ptr[CSA_PW-1], usr_ptr[USR_PW-1]};
  assign irq_o     = flag2 & ~prev_q;
  assign rd_data_o = rd_en_i ? ram_rd : '0;

  a_r9_irq_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  a_r2_idle_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> (rd_data_o == '0));
  a_r6_side_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(aux_we && csb_we));
  a_r7_no_strobe_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sf_valid_i |-> (ram_we == '0));
  a_r8_flags_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sf_valid_i |=> $stable(flag_o[1:0]));
  a_r5_aux_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sf_valid_i && mode == MODE_CS_AUX) |=> $stable(aux_ptr));
  a_r6_csb_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(second_stb && mode == MODE_CS_PAIR) |=> $stable(csb_ptr));
endmodule

// File: tb/sc_side_buffer_tb.sv
`timescale 1ns/1ps
module sc_side_buffer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       sf_valid = 1'b0, sf_second = 1'b0, blk_start = 1'b0;
  logic       c_bit = 1'b0, u_bit = 1'b0;
  logic [3:0] aux = 4'd0;
  logic       rd_en = 1'b0;
  logic [4:0] rd_addr = 5'd0;
  logic [7:0] rd_data;
  logic [2:0] flag;
  logic       irq;

  int n_chk = 0, n_bad = 0;
  string scen = "";

  // reference model state
  int m_mem [32];
  int u_pos, u_acc, a_pos, a_acc, c_pos, c_acc, b_pos, b_acc;
  int c_blk_cnt;
  bit m_prev, m_pend;

  always #2.5 clk = ~clk;

  sc_side_buffer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .sf_valid_i(sf_valid),
    .sf_second_i(sf_second), .blk_start_i(blk_start), .c_bit_i(c_bit),
    .u_bit_i(u_bit), .aux_i(aux), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .flag_o(flag), .irq_o(irq));

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, scen, act, exp);
    end
  endtask

  function automatic bit m_flag2();
    return c_blk_cnt < 8;
  endfunction

  task automatic put(input bit rs, input int nb, input int v, input int base,
                     input int rbytes, inout int pos, inout int acc, output bit com);
    com = 0;
    if (rs) begin pos = 0; acc = 0; end
    acc = acc | (v << (pos % 8));
    pos = pos + nb;
    if (pos % 8 == 0) begin
      m_mem[base + pos / 8 - 1] = acc & 255;
      acc = 0;
      com = 1;
      if (pos == rbytes * 8) pos = 0;
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 32; i++) m_mem[i] = 0;
    u_pos = 0; u_acc = 0; a_pos = 0; a_acc = 0;
    c_pos = 0; c_acc = 0; b_pos = 0; b_acc = 0;
    c_blk_cnt = 0; m_prev = 1; m_pend = 0;
  endtask

  task automatic model_update();
    bit com, rs, f2;
    f2 = m_flag2();
    rs = sf_valid && !sf_second && blk_start;
    if (sf_valid) begin
      put(rs, 1, int'(u_bit), 0, 4, u_pos, u_acc, com);
      if (mode == 2'd1) put(rs, 4, int'(aux), 16, 16, a_pos, a_acc, com);
      if (!sf_second) begin
        if (rs) c_blk_cnt = 0;
        put(rs, 1, int'(c_bit), 8, 8, c_pos, c_acc, com);
        if (com && c_blk_cnt < 8) c_blk_cnt++;
      end else if (mode == 2'd2) begin
        put(m_pend, 1, int'(c_bit), 16, 8, b_pos, b_acc, com);
      end
      if (sf_second) m_pend = 0;
      else if (rs) m_pend = 1;
    end
    m_prev = f2;
  endtask

  task automatic compare();
    string t;
    int a;
    a = int'(rd_addr);
    if (!rd_en || (a >= 4 && a < 8)) t = "R2";
    else if (a < 4) t = "R3";
    else if (a < 16) t = "R4";
    else if (mode == 2'd1) t = "R5";
    else t = "R6";
    chk(t, int'(rd_data), rd_en ? m_mem[a] : 0);
    chk("R7", int'(flag[0]), (u_pos / 8) >= 2);
    chk("R8", int'(flag[1]), (c_pos / 8) >= 4);
    chk("R9", int'(flag[2]), int'(m_flag2()));
    chk("R9", int'(irq), int'(m_flag2() && !m_prev));
  endtask

  // inputs already set; compare, advance model, move to next negedge
  task automatic cyc();
    #1;
    compare();
    model_update();
    @(negedge clk);
  endtask

  task automatic rand_read();
    rd_en   = ($urandom % 4) != 0;
    rd_addr = 5'($urandom);
  endtask

  task automatic sub(input bit second, input bit blk);
    sf_valid = 1; sf_second = second; blk_start = blk;
    c_bit = 1'($urandom); u_bit = 1'($urandom); aux = 4'($urandom);
    rand_read();
    cyc();
    sf_valid = 0; blk_start = 0;
    if (($urandom % 3) == 0) begin rand_read(); cyc(); end
  endtask

  task automatic run(input int frames, input int blk_len, input int off);
    for (int f = 0; f < frames; f++) begin
      sub(1'b0, ((f + off) % blk_len) == 0);
      sub(1'b1, ($urandom % 5) == 0);
    end
  endtask

  task automatic sweep();
    sf_valid = 0;
    for (int r = 0; r < 2; r++)
      for (int i = 0; i < 32; i++) begin
        rd_en = 1; rd_addr = 5'(i);
        cyc();
      end
  endtask

  initial begin
    #900000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    rd_en = 1; rd_addr = 5'd9;
    #12;
    chk("R1", int'(rd_data), 0);
    chk("R1", int'(flag), 3'b100);
    chk("R1", int'(irq), 0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    scen = "R1"; sweep();
    mode = 2'd0; scen = "R4"; run(80, 72, 0); sweep();
    mode = 2'd1; scen = "R5"; run(100, 72, 0); sweep();
    mode = 2'd2; scen = "R6"; run(100, 72, 0); sweep();
    mode = 2'd3; scen = "R6"; run(40, 72, 0); sweep();
    mode = 2'd1; scen = "R10"; run(60, 13, 5); sweep();
    mode = 2'd2; scen = "R10"; run(40, 11, 3); sweep();
    scen = "R2"; sweep();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule